// File: doc/BRIEF.md
# Instruction Address Breakpoint Comparator Unit

This block watches the instruction fetch address and raises a breakpoint request when the fetched halfword lies in a word that software has marked. It has a small set of address comparators (four by default) and one control register. All of them are reached through a plain memory-mapped register port that takes one 32-bit access per cycle, decoded by word offset inside a 4 KB window. A group of read-only identification bytes occupies the top of that window.

Each comparator holds a word address, an enable bit, and a two-bit halfword selector. The selector decides whether a match breaks on the lower halfword, the upper halfword, both, or neither. The control register holds a global enable, and software can change it only by writing a key bit as 1 in the same write. A comparator can hit only when its own enable and the global enable are both set. The request output is the OR of all comparator hits, taken through one register stage.

Top module: `fetch_brk_unit`

## Requirements
- R1: After debug reset (`dbg_rst_n` low), the control register at offset 0x000 reads 0x00000040, with the comparator count in bits 7:4. Every comparator reads 0 and `brk_req` is 0.
- R2: A write to offset 0x000 changes the control register only when write-data bit 1 is 1. Otherwise the write has no effect. Bit 1 reads back as 0, and every bit other than 0 and 7:4 reads as 0.
- R3: Control bit 0 is the global enable. It is readable and writable.
- R4: Comparator i sits at offset 0x008 + 4*i. Its fields are: bits 31:30 are the halfword selector, bits 28:2 are the word address, and bit 0 is the comparator enable. Bits 29 and 1 read as 0.
- R5: The selector value decides which fetches break. 00 never breaks. 01 breaks when fetch address bit 1 is 0. 10 breaks when fetch address bit 1 is 1, which covers the second halfword of a 32-bit instruction. 11 breaks on both halfwords.
- R6: A comparator hits only when all of these hold: `fetch_valid` is 1, its own enable is 1, the global enable is 1, fetch address bits 28:2 equal its word address, and fetch address bits 31:29 are zero.
- R7: `brk_req` is 1 in the cycle after a fetch that hits any comparator. It lasts one cycle per fetch.
- R8: Offsets 0xFD0 through 0xFFC, in steps of 4, read bytes 0x04, 0x00, 0x00, 0x00, 0x0B, 0xB0, 0x0B, 0x00, 0x0D, 0xE0, 0x05 and 0xB1 in bits 7:0, with bits 31:8 zero.
- R9: Reads of unmapped offsets return 0. Writes to unmapped offsets or to the identification bytes change no readable state.
- R10: A fetch presented in the same cycle as a write to a comparator is compared against that comparator's contents from before the write.
- R11: Asserting `dbg_rst_n` during operation clears the global enable and all comparator enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| dbg_rst_n | input | 1 | Asynchronous debug reset, active low |
| reg_valid | input | 1 | Register access in this cycle |
| reg_write | input | 1 | 1 for write, 0 for read |
| reg_addr | input | 12 | Byte offset in the 4 KB window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the same cycle as a read |
| fetch_valid | input | 1 | Fetch address is valid |
| fetch_addr | input | 32 | Instruction fetch address |
| brk_req | output | 1 | Breakpoint request, registered |

## Verification
A comparator write and a fetch compare can fall in the same clock cycle. The two functions then disagree about which comparator contents apply. The bench provokes this in two ways: it disables a matching comparator in the same cycle as a matching fetch, and it enables a comparator in the same cycle as a fetch. It judges `brk_req` one cycle later against the contents from before the write. A second overlap is a key-less control write that arrives while comparators are armed. The bench checks that the global enable, and with it the break behaviour, survives that write.

// File: rtl/fbu_pkg.sv
package fbu_pkg;
   localparam int REG_AW        = 12;
   localparam int FA_W          = 32;
   localparam int CMP_MSB       = 28;
   localparam int CMP_LSB       = 2;
   localparam int CMP_W         = CMP_MSB - CMP_LSB + 1;
   localparam int CMP_BASE_WORD = 2;
   localparam int ID_FIRST_WORD = 'hFD0 >> 2;
   localparam int ID_COUNT      = 12;

   typedef enum logic [1:0] {
      HW_NONE = 2'b00,
      HW_LOW  = 2'b01,
      HW_HIGH = 2'b10,
      HW_BOTH = 2'b11
   } hw_sel_e;

   typedef struct packed {
      hw_sel_e          sel;
      logic [CMP_W-1:0] waddr;
      logic             en;
   } cmp_cfg_t;

   function automatic logic [31:0] cfg_to_word(cmp_cfg_t c);
      return {c.sel, 1'b0, c.waddr, 1'b0, c.en};
   endfunction
endpackage

// File: rtl/fbu_id_rom.sv
module fbu_id_rom #(
   parameter bit HAS_ID = 1'b1
) (
   input  logic [3:0] idx,
   output logic [7:0] val
);
   generate
      if (HAS_ID) begin : g_rom
         always_comb begin
            case (idx)
               4'd0:    val = 8'h04;
               4'd4:    val = 8'h0B;
               4'd5:    val = 8'hB0;
               4'd6:    val = 8'h0B;
               4'd8:    val = 8'h0D;
               4'd9:    val = 8'hE0;
               4'd10:   val = 8'h05;
               4'd11:   val = 8'hB1;
               default: val = 8'h00;
            endcase
         end
      end else begin : g_blank
         assign val = 8'h00;
      end
   endgenerate
endmodule

// File: rtl/fbu_cmp.sv
module fbu_cmp
   import fbu_pkg::*;
#(
   parameter bit CHECK_TOP = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [31:0]     wdata,
   input  logic            glob_en,
   input  logic            fetch_valid,
   input  logic [FA_W-1:0] fetch_addr,
   output cmp_cfg_t        cfg,
   output logic            hit
);
   logic       top_ok;
   logic       word_eq;
   logic       hw_ok;
   logic [1:0] sel_bits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg <= '0;
      end else if (wr_en) begin
         cfg.sel   <= hw_sel_e'(wdata[31:30]);
         cfg.waddr <= wdata[CMP_MSB:CMP_LSB];
         cfg.en    <= wdata[0];
      end
   end

   generate
      if (CHECK_TOP) begin : g_top_chk
         assign top_ok = (fetch_addr[FA_W-1:CMP_MSB+1] == '0);
      end else begin : g_top_free
         assign top_ok = 1'b1;
      end
   endgenerate

   assign sel_bits = cfg.sel;
   assign word_eq  = (fetch_addr[CMP_MSB:CMP_LSB] == cfg.waddr);
   assign hw_ok    = fetch_addr[1] ? sel_bits[1] : sel_bits[0];
   assign hit      = glob_en & cfg.en & fetch_valid & top_ok & word_eq & hw_ok;

   // R9
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(cfg));
endmodule

// File: rtl/fbu_regs.sv
module fbu_regs
   import fbu_pkg::*;
#(
   parameter int NUM_CMP = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    reg_valid,
   input  logic                    reg_write,
   input  logic [REG_AW-1:0]       reg_addr,
   input  logic [31:0]             reg_wdata,
   input  logic [NUM_CMP-1:0][31:0] cfg_words,
   input  logic [7:0]              id_val,
   output logic [31:0]             reg_rdata,
   output logic                    glob_en,
   output logic [NUM_CMP-1:0]      cmp_wr,
   output logic [3:0]              id_idx
);
   localparam int WIDX_W = REG_AW - 2;
   localparam logic [WIDX_W-1:0] ID_W0 = WIDX_W'(ID_FIRST_WORD);

   logic [WIDX_W-1:0] widx;
   logic              wr_any;
   logic              rd_any;
   logic              ctrl_sel;
   logic              id_sel;

   assign widx     = reg_addr[REG_AW-1:2];
   assign wr_any   = reg_valid & reg_write;
   assign rd_any   = reg_valid & ~reg_write;
   assign ctrl_sel = (widx == '0);
   assign id_sel   = (widx >= ID_W0);
   assign id_idx   = 4'(widx - ID_W0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         glob_en <= 1'b0;
      end else if (wr_any && ctrl_sel && reg_wdata[1]) begin
         glob_en <= reg_wdata[0];
      end
   end

   generate
      for (genvar gi = 0; gi < NUM_CMP; gi++) begin : g_wr
         assign cmp_wr[gi] = wr_any && (widx == WIDX_W'(CMP_BASE_WORD + gi));
      end
   endgenerate

   always_comb begin
      reg_rdata = '0;
      if (rd_any) begin
         if (ctrl_sel) begin
            reg_rdata[7:4] = 4'(NUM_CMP);
            reg_rdata[0]   = glob_en;
         end
         for (int i = 0; i < NUM_CMP; i++) begin
            if (widx == WIDX_W'(CMP_BASE_WORD + i)) reg_rdata = cfg_words[i];
         end
         if (id_sel) reg_rdata[7:0] = id_val;
      end
   end

   // R2
   key_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_any && ctrl_sel && !reg_wdata[1]) |=> $stable(glob_en));

   // R9
   ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_any && !ctrl_sel) |=> $stable(glob_en));
endmodule

// File: rtl/fetch_brk_unit.sv
module fetch_brk_unit
   import fbu_pkg::*;
#(
   parameter int NUM_CMP   = 4,
   parameter bit CHECK_TOP = 1'b1,
   parameter bit HAS_ID    = 1'b1
) (
   input  logic        clk,
   input  logic        dbg_rst_n,
   input  logic        reg_valid,
   input  logic        reg_write,
   input  logic [11:0] reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   input  logic        fetch_valid,
   input  logic [31:0] fetch_addr,
   output logic        brk_req
);
   generate
      if (NUM_CMP < 1 || NUM_CMP > 15) begin : g_bad_cnt
         $error("fetch_brk_unit: NUM_CMP must lie in 1..15");
      end
   endgenerate

   logic                     glob_en;
   logic [NUM_CMP-1:0]       cmp_wr;
   logic [NUM_CMP-1:0]       hits;
   logic [NUM_CMP-1:0][31:0] cfg_words;
   logic [3:0]               id_idx;
   logic [7:0]               id_val;

   fbu_regs #(.NUM_CMP(NUM_CMP)) u_regs (
      .clk       (clk),
      .rst_n     (dbg_rst_n),
      .reg_valid (reg_valid),
      .reg_write (reg_write),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .cfg_words (cfg_words),
      .id_val    (id_val),
      .reg_rdata (reg_rdata),
      .glob_en   (glob_en),
      .cmp_wr    (cmp_wr),
      .id_idx    (id_idx)
   );

   fbu_id_rom #(.HAS_ID(HAS_ID)) u_id (
      .idx (id_idx),
      .val (id_val)
   );

   generate
      for (genvar gi = 0; gi < NUM_CMP; gi++) begin : g_cmp
         cmp_cfg_t cfg;
         fbu_cmp #(.CHECK_TOP(CHECK_TOP)) u_cmp (
            .clk         (clk),
            .rst_n       (dbg_rst_n),
            .wr_en       (cmp_wr[gi]),
            .wdata       (reg_wdata),
            .glob_en     (glob_en),
            .fetch_valid (fetch_valid),
            .fetch_addr  (fetch_addr),
            .cfg         (cfg),
            .hit         (hits[gi])
         );
         assign cfg_words[gi] = cfg_to_word(cfg);
      end
   endgenerate

   always_ff @(posedge clk or negedge dbg_rst_n) begin
      if (!dbg_rst_n) brk_req <= 1'b0;
      else            brk_req <= |hits;
   end

   // R7
   brk_fetch_chk: assert property (@(posedge clk) disable iff (!dbg_rst_n)
      brk_req |-> $past(fetch_valid));

   // R6
   brk_glob_chk: assert property (@(posedge clk) disable iff (!dbg_rst_n)
      brk_req |-> $past(glob_en));
endmodule

// File: tb/sim_fetch_brk_unit.sv
`timescale 1ns/1ps
module sim_fetch_brk_unit;
   logic        clk = 1'b0;
   logic        dbg_rst_n = 1'b0;
   logic        reg_valid = 1'b0;
   logic        reg_write = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        fetch_valid = 1'b0;
   logic [31:0] fetch_addr = '0;
   logic        brk_req;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   fetch_brk_unit u0 (
      .clk(clk), .dbg_rst_n(dbg_rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .brk_req(brk_req)
   );

   function automatic logic [31:0] mk(input logic [1:0] sel, input logic [31:0] a, input logic en);
      return {sel, 30'b0} | (a & 32'h1FFF_FFFC) | {31'b0, en};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_valid = 1'b0; reg_write = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
      #2 d = reg_rdata;
      reg_valid = 1'b0;
   endtask

   task automatic fetch(input logic [31:0] a, output logic b);
      @(negedge clk);
      fetch_valid = 1'b1; fetch_addr = a;
      @(negedge clk);
      fetch_valid = 1'b0;
      #1 b = brk_req;
   endtask

   task automatic do_reset();
      @(negedge clk); dbg_rst_n = 1'b0;
      @(negedge clk); @(negedge clk); dbg_rst_n = 1'b1;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      rd(12'h000, d); chk("R1 ctrl reset", d, 32'h40);
      for (int i = 0; i < 4; i++) begin
         rd(12'(8 + 4*i), d); chk("R1 cmp reset", d, 32'h0);
      end
      chk("R1 brk reset", {31'b0, brk_req}, 32'h0);
   endtask

   task automatic t_id();
      logic [31:0] d;
      logic [7:0] exp_id [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h0B, 8'hB0,
                                  8'h0B, 8'h00, 8'h0D, 8'hE0, 8'h05, 8'hB1};
      for (int i = 0; i < 12; i++) begin
         rd(12'(12'hFD0 + 4*i), d); chk("R8 id byte", d, {24'b0, exp_id[i]});
      end
   endtask

   task automatic t_key();
      logic [31:0] d;
      wr(12'h000, 32'h1); rd(12'h000, d); chk("R2 no key", d, 32'h40);
      wr(12'h000, 32'h3); rd(12'h000, d); chk("R3 enable set", d, 32'h41);
      wr(12'h000, 32'h0); rd(12'h000, d); chk("R2 no key clear", d, 32'h41);
      wr(12'h000, 32'h2); rd(12'h000, d); chk("R3 enable clear", d, 32'h40);
      wr(12'h000, 32'hFFFF_FFFF); rd(12'h000, d); chk("R2 ro bits", d, 32'h41);
   endtask

   task automatic t_fields();
      logic [31:0] d;
      wr(12'h00C, 32'hFFFF_FFFF); rd(12'h00C, d); chk("R4 field mask", d, 32'hDFFF_FFFD);
      wr(12'h00C, 32'h0); rd(12'h00C, d); chk("R4 field clear", d, 32'h0);
   endtask

   task automatic t_modes();
      logic b;
      wr(12'h000, 32'h3);
      for (int s = 0; s < 4; s++) begin
         wr(12'h008, mk(2'(s), 32'h1000, 1'b1));
         fetch(32'h1000, b); chk("R5 lower half", {31'b0, b}, {31'b0, s[0]});
         fetch(32'h1002, b); chk("R5 upper half", {31'b0, b}, {31'b0, s[1]});
      end
      fetch(32'h1004, b); chk("R6 other word", {31'b0, b}, 32'h0);
      @(negedge clk); #1 chk("R7 single pulse", {31'b0, brk_req}, 32'h0);
   endtask

   task automatic t_enables();
      logic b;
      wr(12'h010, mk(2'b11, 32'h2000, 1'b0));
      fetch(32'h2000, b); chk("R6 cmp disabled", {31'b0, b}, 32'h0);
      wr(12'h010, mk(2'b11, 32'h2000, 1'b1));
      wr(12'h000, 32'h2);
      fetch(32'h2000, b); chk("R6 glob disabled", {31'b0, b}, 32'h0);
      wr(12'h000, 32'h3);
      fetch(32'h2000, b); chk("R6 both enabled", {31'b0, b}, 32'h1);
      fetch(32'h2000_2000, b); chk("R6 top bits", {31'b0, b}, 32'h0);
      wr(12'h000, 32'h0);
      fetch(32'h2002, b); chk("R2 keyless keeps enable", {31'b0, b}, 32'h1);
      wr(12'h014, mk(2'b01, 32'h3000, 1'b1));
      fetch(32'h3000, b); chk("R7 or of comparators", {31'b0, b}, 32'h1);
      @(negedge clk); #1 chk("R7 drops", {31'b0, brk_req}, 32'h0);
      fetch(32'h3002, b); chk("R5 upper not selected", {31'b0, b}, 32'h0);
   endtask

   task automatic t_unmapped();
      logic [31:0] d;
      rd(12'h004, d); chk("R9 read gap", d, 32'h0);
      rd(12'h018, d); chk("R9 read past cmps", d, 32'h0);
      rd(12'h800, d); chk("R9 read mid", d, 32'h0);
      wr(12'h004, 32'hFFFF_FFFF);
      wr(12'h018, 32'hFFFF_FFFF);
      wr(12'hFD0, 32'hFFFF_FFFF);
      rd(12'hFD0, d); chk("R9 id unchanged", d, 32'h04);
      rd(12'h004, d); chk("R9 gap still zero", d, 32'h0);
      rd(12'h000, d); chk("R9 ctrl unchanged", d, 32'h41);
      rd(12'h014, d); chk("R9 cmp unchanged", d, mk(2'b01, 32'h3000, 1'b1));
   endtask

   task automatic t_same_cycle();
      wr(12'h008, mk(2'b11, 32'h4000, 1'b1));
      @(negedge clk);
      reg_valid = 1'b1; reg_write = 1'b1; reg_addr = 12'h008;
      reg_wdata = mk(2'b11, 32'h4000, 1'b0);
      fetch_valid = 1'b1; fetch_addr = 32'h4000;
      @(negedge clk);
      reg_valid = 1'b0; reg_write = 1'b0; fetch_valid = 1'b0;
      #1 chk("R10 old contents hit", {31'b0, brk_req}, 32'h1);
      @(negedge clk);
      reg_valid = 1'b1; reg_write = 1'b1; reg_addr = 12'h008;
      reg_wdata = mk(2'b11, 32'h4000, 1'b1);
      fetch_valid = 1'b1; fetch_addr = 32'h4002;
      @(negedge clk);
      reg_valid = 1'b0; reg_write = 1'b0; fetch_valid = 1'b0;
      #1 chk("R10 old contents miss", {31'b0, brk_req}, 32'h0);
   endtask

   task automatic t_dbg_reset();
      logic [31:0] d;
      logic b;
      do_reset();
      rd(12'h000, d); chk("R11 glob cleared", d, 32'h40);
      rd(12'h010, d); chk("R11 cmp cleared", d, 32'h0);
      fetch(32'h2000, b); chk("R11 no break", {31'b0, b}, 32'h0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      @(negedge clk); @(negedge clk);
      dbg_rst_n = 1'b1;
      t_reset();
      t_id();
      t_key();
      t_fields();
      t_modes();
      t_enables();
      t_unmapped();
      t_same_cycle();
      t_dbg_reset();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule